// File: doc/BRIEF.md
# Frame Job Queue Controller

This block is the command, status and interrupt front end of a camera-frame processing engine. Software reaches it over a simple 32-bit register bus with a combinational read port. It fills a small staged configuration window and then issues a queue command. The staged words are promoted into the live configuration, which drives the pixel pipeline, at the next start-of-frame pulse. From then on the job is tracked through the queued, waiting and active states until the end-of-frame pulse.

Status values are not read live. A latch command takes a coherent snapshot of the job state, the completed-frame count, the error flags and the two output line counters, and all later reads return that snapshot. Each output has a programmable line threshold that raises its own interrupt bit. A single level interrupt is driven whenever an enabled pending bit is set. Abort and soft-reset commands bring the job state back to idle in one cycle.

Top module: `frame_job_ctrl`

## Requirements
- R1: Reading address 0x000 returns the version word, with the major revision (default 2) in bits 31:24, the minor revision (default 1) in bits 23:20 and zeros elsewhere.
- R2: Word-aligned writes to the window from 0x040 (8 words by default) set staged configuration words that read back at the same address. Addresses outside the window read as zero. Staging has no effect on the live configuration output before a promotion.
- R3: Writing 1 to control bit 0 (address 0x004) on an idle block sets status bit 0 (queued) and bit 1 (waiting). Status at 0x008 reads {active in bit 2, waiting in bit 1, queued in bit 0}. The 0x008, 0x00C, 0x010 and 0x014 registers show only the values captured by the last write of 1 to control bit 3.
- R4: A start-of-frame pulse while queued copies every staged word into the live configuration, clears queued and waiting, sets active (status 4), and sets interrupt bit 1 (start of frame) and bit 24 (queue ready). An end-of-frame pulse while active clears active, increments the frame count at 0x00C and sets interrupt bit 0.
- R5: A queue command while queued is already set is refused: status is unchanged and error status (0x010) bit 1 is set.
- R6: Writing 1 to control bit 1 (abort) makes the status zero on the next cycle and drops any queued job, so a later start-of-frame promotes nothing.
- R7: Writing 1 to control bit 2 (soft reset) returns the state to idle and clears interrupt status, error status and the frame count.
- R8: The thresholds for outputs 0 and 1 are bits 15:0 of live words 0 and 1. Each output counter restarts at promotion and counts line pulses while active. When a count reaches a nonzero threshold, interrupt bit 8 (output 0) or bit 9 (output 1) is set. Output status (0x014) holds {count1 in bits 31:16, count0 in bits 15:0}.
- R9: Interrupt status (0x01C) is write-one-to-clear, and an event in the same cycle as a clear wins. Events, including statistics-done (bit 16), set their bits even when masked. The enable register (0x018) keeps only bits 0, 1, 8, 9, 16 and 24, and `irq` is high exactly when an enabled bit is pending.
- R10: A start-of-frame pulse while active sets error status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Byte address of the register access |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRead | input | 1 | Read enable; read data is zero when low |
| busRdata | output | 32 | Combinational read data |
| sofPulse | input | 1 | Start-of-frame pulse from the pixel path |
| eofPulse | input | 1 | End-of-frame pulse from the pixel path |
| lineDone | input | 2 | Per-output line-complete pulses |
| statsDone | input | 1 | Statistics-complete pulse |
| liveCfg | output | 256 | Live configuration words, word 0 in the low bits |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a job queued behind a frame that is still active, followed by an abort before the next frame start. The stimulus promotes one job, issues a second queue command during the frame, and rewrites a staged word after it is queued. It then aborts and sends a start-of-frame pulse, so the discarded job shows up at the live configuration port as a word that did not change. Refused queue commands and overrun frame starts are driven on purpose, and their error flags are read back through the latched snapshot.

// File: rtl/fjq_pkg.sv
package fjq_pkg;
  localparam int NUM_OUT = 2;

  localparam int INT_EOF    = 0;
  localparam int INT_SOF    = 1;
  localparam int INT_LINE0  = 8;
  localparam int INT_STATS  = 16;
  localparam int INT_QREADY = 24;
  localparam logic [31:0] INT_MASK = 32'h0101_0303;

  localparam logic [11:0] REG_VERSION = 12'h000;
  localparam logic [11:0] REG_CTRL    = 12'h004;
  localparam logic [11:0] REG_STATUS  = 12'h008;
  localparam logic [11:0] REG_FRAME   = 12'h00C;
  localparam logic [11:0] REG_ERROR   = 12'h010;
  localparam logic [11:0] REG_OUTPUT  = 12'h014;
  localparam logic [11:0] REG_INTEN   = 12'h018;
  localparam logic [11:0] REG_INTSTS  = 12'h01C;
  localparam logic [11:0] CFG_BASE    = 12'h040;

  typedef struct packed {
    logic queue;
    logic abort;
    logic softReset;
  } cmd_t;

  typedef struct packed {
    logic               promote;
    logic               sofEvt;
    logic               eofEvt;
    logic               qReady;
    logic [NUM_OUT-1:0] lineHit;
    logic               errOverrun;
    logic               errReject;
    logic               frameDone;
  } strobe_t;
endpackage

// File: rtl/fjq_control.sv
module fjq_control
  import fjq_pkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cmd_t                      cmd,
  input  logic                      sofPulse,
  input  logic                      eofPulse,
  input  logic [NUM_OUT-1:0]        lineDone,
  input  logic [NUM_OUT*LINE_W-1:0] thresh,
  output strobe_t                   strb,
  output logic [2:0]                stateBits,
  output logic [NUM_OUT*LINE_W-1:0] lineCount
);
  logic queued, active;
  logic kill, acceptQ, promote;
  logic [NUM_OUT-1:0] lineHitVec;

  assign kill    = cmd.abort | cmd.softReset;
  assign acceptQ = cmd.queue & ~queued & ~kill;
  assign promote = sofPulse & queued & ~kill;

  always_comb begin
    strb            = '0;
    strb.promote    = promote;
    strb.sofEvt     = sofPulse;
    strb.eofEvt     = eofPulse;
    strb.qReady     = promote;
    strb.lineHit    = lineHitVec;
    strb.errOverrun = sofPulse & active & ~kill;
    strb.errReject  = cmd.queue & queued & ~kill;
    strb.frameDone  = eofPulse & active & ~kill;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      queued <= 1'b0;
      active <= 1'b0;
    end else if (kill) begin
      queued <= 1'b0;
      active <= 1'b0;
    end else begin
      if (promote)      queued <= 1'b0;
      else if (acceptQ) queued <= 1'b1;
      if (promote)                active <= 1'b1;
      else if (eofPulse & active) active <= 1'b0;
    end
  end

  assign stateBits = {active, queued & ~active, queued};

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
    logic [LINE_W-1:0] cnt;
    logic [LINE_W-1:0] thr;
    logic [LINE_W-1:0] cntNext;
    assign thr     = thresh[i*LINE_W +: LINE_W];
    assign cntNext = cnt + LINE_W'(1);
    assign lineHitVec[i] = active & lineDone[i] & ~kill & ~promote &
                           (thr != '0) & (cntNext == thr);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     cnt <= '0;
      else if (kill || promote)      cnt <= '0;
      else if (active && lineDone[i]) cnt <= cntNext;
    end
    assign lineCount[i*LINE_W +: LINE_W] = cnt;
  end
endmodule

// File: rtl/fjq_datapath.sv
module fjq_datapath
  import fjq_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          CFG_WORDS = 8,
  parameter int          LINE_W    = 16,
  parameter logic [7:0]  VER_MAJOR = 8'h02,
  parameter logic [3:0]  VER_MINOR = 4'h1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      busWrite,
  input  logic [31:0]               busWdata,
  input  logic                      busRead,
  output logic [31:0]               busRdata,
  input  logic                      statsDone,
  input  strobe_t                   strb,
  input  logic [2:0]                stateBits,
  input  logic [NUM_OUT*LINE_W-1:0] lineCount,
  output cmd_t                      cmd,
  output logic [NUM_OUT*LINE_W-1:0] thresh,
  output logic [CFG_WORDS*32-1:0]   liveCfg,
  output logic [31:0]               intSts,
  output logic                      irq
);
  localparam int WA_W      = ADDR_W - 2;
  localparam int CFG_IDX_W = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;
  localparam logic [WA_W-1:0] CFG_FIRST = WA_W'(CFG_BASE >> 2);
  localparam logic [WA_W-1:0] CFG_END   = WA_W'((CFG_BASE >> 2) + CFG_WORDS);
  localparam logic [31:0] VERSION_WORD = {VER_MAJOR, VER_MINOR, 20'h0};

  logic [31:0] staged [CFG_WORDS];
  logic [31:0] live   [CFG_WORDS];
  logic [31:0] intEn, errSts, frameCnt;
  logic [31:0] shStatus, shFrame, shError, shOutput;
  logic [WA_W-1:0] wordAddr, cfgOffs;
  logic aligned, inWin, wrCtrl, wrIntEn, wrIntSts, latchCmd;
  logic [31:0] setVec, clrVec, rdMux;

  assign wordAddr = busAddr[ADDR_W-1:2];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign inWin    = aligned && (wordAddr >= CFG_FIRST) && (wordAddr < CFG_END);
  assign cfgOffs  = wordAddr - CFG_FIRST;

  assign wrCtrl   = busWrite && (busAddr == ADDR_W'(REG_CTRL));
  assign wrIntEn  = busWrite && (busAddr == ADDR_W'(REG_INTEN));
  assign wrIntSts = busWrite && (busAddr == ADDR_W'(REG_INTSTS));
  assign latchCmd = wrCtrl & busWdata[3];

  always_comb begin
    cmd           = '0;
    cmd.queue     = wrCtrl & busWdata[0];
    cmd.abort     = wrCtrl & busWdata[1];
    cmd.softReset = wrCtrl & busWdata[2];
  end

  // Staged and live configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < CFG_WORDS; w++) begin
        staged[w] <= '0;
        live[w]   <= '0;
      end
    end else begin
      for (int w = 0; w < CFG_WORDS; w++) begin
        if (busWrite && inWin && (cfgOffs == WA_W'(w))) staged[w] <= busWdata;
        if (strb.promote) live[w] <= staged[w];
      end
    end
  end

  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_live
    assign liveCfg[w*32 +: 32] = live[w];
  end
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_thr
    assign thresh[i*LINE_W +: LINE_W] = live[i][LINE_W-1:0];
  end

  // Interrupt status: events set, software clears, events win
  always_comb begin
    setVec = '0;
    setVec[INT_EOF]    = strb.eofEvt;
    setVec[INT_SOF]    = strb.sofEvt;
    setVec[INT_STATS]  = statsDone;
    setVec[INT_QREADY] = strb.qReady;
    for (int i = 0; i < NUM_OUT; i++) setVec[INT_LINE0+i] = strb.lineHit[i];
    clrVec = wrIntSts ? busWdata : 32'h0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intSts   <= '0;
      intEn    <= '0;
      errSts   <= '0;
      frameCnt <= '0;
    end else begin
      if (wrIntEn) intEn <= busWdata & INT_MASK;
      if (cmd.softReset) begin
        intSts   <= '0;
        errSts   <= '0;
        frameCnt <= '0;
      end else begin
        intSts <= ((intSts & ~clrVec) | setVec) & INT_MASK;
        errSts <= errSts | {30'h0, strb.errReject, strb.errOverrun};
        if (strb.frameDone) frameCnt <= frameCnt + 32'd1;
      end
    end
  end

  // Coherent snapshot of live status values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shStatus <= '0;
      shFrame  <= '0;
      shError  <= '0;
      shOutput <= '0;
    end else if (latchCmd) begin
      shStatus <= {29'h0, stateBits};
      shFrame  <= frameCnt;
      shError  <= errSts;
      shOutput <= 32'(lineCount);
    end
  end

  always_comb begin
    rdMux = '0;
    if (inWin) begin
      rdMux = staged[cfgOffs[CFG_IDX_W-1:0]];
    end else begin
      case (busAddr)
        ADDR_W'(REG_VERSION): rdMux = VERSION_WORD;
        ADDR_W'(REG_STATUS):  rdMux = shStatus;
        ADDR_W'(REG_FRAME):   rdMux = shFrame;
        ADDR_W'(REG_ERROR):   rdMux = shError;
        ADDR_W'(REG_OUTPUT):  rdMux = shOutput;
        ADDR_W'(REG_INTEN):   rdMux = intEn;
        ADDR_W'(REG_INTSTS):  rdMux = intSts;
        default:              rdMux = '0;
      endcase
    end
  end

  assign busRdata = busRead ? rdMux : 32'h0;
  assign irq      = |(intSts & intEn);
endmodule

// File: rtl/frame_job_ctrl.sv
module frame_job_ctrl
  import fjq_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter int         CFG_WORDS = 8,
  parameter int         LINE_W    = 16,
  parameter logic [7:0] VER_MAJOR = 8'h02,
  parameter logic [3:0] VER_MINOR = 4'h1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrite,
  input  logic [31:0]             busWdata,
  input  logic                    busRead,
  output logic [31:0]             busRdata,
  input  logic                    sofPulse,
  input  logic                    eofPulse,
  input  logic [1:0]              lineDone,
  input  logic                    statsDone,
  output logic [CFG_WORDS*32-1:0] liveCfg,
  output logic                    irq
);
  cmd_t                      cmd;
  strobe_t                   strb;
  logic [2:0]                stateBits;
  logic [NUM_OUT*LINE_W-1:0] lineCount;
  logic [NUM_OUT*LINE_W-1:0] thresh;
  logic [31:0]               intSts;

  fjq_control #(.LINE_W(LINE_W)) i_control (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sofPulse(sofPulse),
    .eofPulse(eofPulse), .lineDone(lineDone), .thresh(thresh),
    .strb(strb), .stateBits(stateBits), .lineCount(lineCount)
  );

  fjq_datapath #(
    .ADDR_W(ADDR_W), .CFG_WORDS(CFG_WORDS), .LINE_W(LINE_W),
    .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRead(busRead), .busRdata(busRdata),
    .statsDone(statsDone), .strb(strb), .stateBits(stateBits),
    .lineCount(lineCount), .cmd(cmd), .thresh(thresh),
    .liveCfg(liveCfg), .intSts(intSts), .irq(irq)
  );
endmodule

// File: rtl/fjq_checker.sv
module fjq_checker
  import fjq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input cmd_t        cmd,
  input strobe_t     strb,
  input logic [2:0]  stateBits,
  input logic [31:0] intSts
);
  assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.abort |=> (stateBits == 3'b000));

  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.softReset |=> (stateBits == 3'b000) && (intSts == 32'h0));

  assert_promote_active_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.promote |=> (stateBits == 3'b100));

  assert_qready_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.qReady && !cmd.softReset) |=> intSts[INT_QREADY]);

  assert_waiting_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    stateBits[1] |-> (stateBits[0] && !stateBits[2]));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_hit
    assert_line_hit_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strb.lineHit[i] && !cmd.softReset) |=> intSts[INT_LINE0+i]);
  end
endmodule

bind frame_job_ctrl fjq_checker i_checker (
  .clk(clk), .rstN(rstN), .cmd(cmd), .strb(strb),
  .stateBits(stateBits), .intSts(intSts)
);

// File: tb/test_frame_job_ctrl.sv
module test_frame_job_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRead = 1'b0;
  logic [31:0] busRdata;
  logic        sofPulse = 1'b0, eofPulse = 1'b0, statsDone = 1'b0;
  logic [1:0]  lineDone = 2'b00;
  logic [255:0] liveCfg;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  frame_job_ctrl i_frame_job_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRead(busRead), .busRdata(busRdata),
    .sofPulse(sofPulse), .eofPulse(eofPulse), .lineDone(lineDone),
    .statsDone(statsDone), .liveCfg(liveCfg), .irq(irq)
  );

  // {address, write data, expected read}
  localparam logic [75:0] VEC [8] = '{
    {12'h040, 32'h0000_0003, 32'h0000_0003},
    {12'h044, 32'h0000_0002, 32'h0000_0002},
    {12'h048, 32'hA5A5_1234, 32'hA5A5_1234},
    {12'h04C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {12'h058, 32'h1357_9BDF, 32'h1357_9BDF},
    {12'h05C, 32'hFFFF_0001, 32'hFFFF_0001},
    {12'h060, 32'h7777_7777, 32'h0000_0000},
    {12'h03C, 32'h5555_5555, 32'h0000_0000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    busAddr = a; busRead = 1'b1;
    #1;
    d = busRdata;
    busRead = 1'b0;
  endtask

  task automatic latchRd(logic [11:0] a, output logic [31:0] d);
    wr(12'h004, 32'h8);
    rd(a, d);
  endtask

  task automatic pulseSof();
    @(negedge clk); sofPulse = 1'b1; @(negedge clk); sofPulse = 1'b0;
  endtask

  task automatic pulseEof();
    @(negedge clk); eofPulse = 1'b1; @(negedge clk); eofPulse = 1'b0;
  endtask

  task automatic pulseLine(logic [1:0] m);
    @(negedge clk); lineDone = m; @(negedge clk); lineDone = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    check("R9 irq after reset", {31'h0, irq}, 32'h0);
    rd(12'h000, v); check("R1 version", v, 32'h0210_0000);
    rd(12'h018, v); check("R9 enable after reset", v, 32'h0);
    latchRd(12'h008, v); check("R3 idle status", v, 32'h0);

    // Configuration window vectors
    for (int k = 0; k < 8; k++) begin
      wr(VEC[k][75:64], VEC[k][63:32]);
      rd(VEC[k][75:64], v);
      check("R2 window readback", v, VEC[k][31:0]);
    end
    check("R2 live untouched", liveCfg[31:0], 32'h0);

    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, v); check("R9 enable mask", v, 32'h0101_0303);

    // Queue and snapshot
    wr(12'h004, 32'h1);
    rd(12'h008, v); check("R3 snapshot stale before latch", v, 32'h0);
    latchRd(12'h008, v); check("R3 queued and waiting", v, 32'h3);

    wr(12'h004, 32'h1);
    latchRd(12'h010, v); check("R5 reject error bit", v, 32'h2);
    rd(12'h008, v); check("R5 status unchanged", v, 32'h3);

    // Promotion
    pulseSof();
    rd(12'h01C, v); check("R4 sof and queue ready", v, 32'h0100_0002);
    check("R4 live word0", liveCfg[31:0], 32'h3);
    check("R4 live word3", liveCfg[127:96], 32'hDEAD_BEEF);
    check("R9 irq raised", {31'h0, irq}, 32'h1);
    latchRd(12'h008, v); check("R4 active", v, 32'h4);

    wr(12'h01C, 32'h0100_0002);
    rd(12'h01C, v); check("R9 w1c clears", v, 32'h0);
    check("R9 irq drops", {31'h0, irq}, 32'h0);

    // Line thresholds (3 for output 0, 2 for output 1)
    pulseLine(2'b01); pulseLine(2'b01);
    rd(12'h01C, v); check("R8 below threshold", v, 32'h0);
    pulseLine(2'b01);
    rd(12'h01C, v); check("R8 output0 hit", v, 32'h0000_0100);
    pulseLine(2'b10); pulseLine(2'b10);
    rd(12'h01C, v); check("R8 output1 hit", v, 32'h0000_0300);
    latchRd(12'h014, v); check("R8 output counts", v, 32'h0002_0003);

    // Masked events and set-wins-over-clear
    wr(12'h018, 32'h0);
    @(negedge clk);
    busAddr = 12'h01C; busWdata = 32'hFFFF_FFFF; busWrite = 1'b1; statsDone = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; statsDone = 1'b0;
    rd(12'h01C, v); check("R9 set wins clear", v, 32'h0001_0000);
    check("R9 masked no irq", {31'h0, irq}, 32'h0);

    // End of frame
    pulseEof();
    rd(12'h01C, v); check("R4 eof bit", v & 32'h1, 32'h1);
    latchRd(12'h00C, v); check("R4 frame count", v, 32'h1);
    rd(12'h008, v); check("R4 idle after eof", v, 32'h0);

    // Overrun frame start
    wr(12'h004, 32'h1);
    pulseSof();
    pulseSof();
    latchRd(12'h010, v); check("R10 overrun error", v & 32'h1, 32'h1);

    // Abort drops a job queued behind an active frame
    wr(12'h004, 32'h1);
    latchRd(12'h008, v); check("R3 queued while active", v, 32'h5);
    wr(12'h048, 32'h0BAD_0BAD);
    wr(12'h004, 32'h2);
    latchRd(12'h008, v); check("R6 idle after abort", v, 32'h0);
    pulseSof();
    latchRd(12'h008, v); check("R6 no promotion after abort", v, 32'h0);
    check("R6 live unchanged", liveCfg[95:64], 32'hA5A5_1234);

    // Soft reset
    wr(12'h004, 32'h1);
    pulseSof();
    wr(12'h004, 32'h4);
    rd(12'h01C, v); check("R7 int status cleared", v, 32'h0);
    latchRd(12'h008, v); check("R7 state idle", v, 32'h0);
    rd(12'h010, v); check("R7 errors cleared", v, 32'h0);
    rd(12'h00C, v); check("R7 frame count cleared", v, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule